// File: doc/BRIEF.md
# Four-Channel Mixed-Priority Transfer Request Arbiter

This block decides which of four transfer channels owns the data mover next. Each channel raises a request line; the arbiter answers with a registered one-hot grant. The grant stays put until the transfer-done pulse arrives. A two-bit priority selector picks the scheme. The choices are plain rotation over all four channels, strict fixed order, or two mixed schemes in which one or two low-numbered channels win outright and the remaining channels take turns in a rotating group.

An eight-bit control byte is written through a simple write strobe and read back on a dedicated output. Besides the priority selector it holds a master enable, a self-clearing software-reset trigger and a two-bit double-buffer pairing code. The pairing code is only decoded onto two flag outputs; the channel switching it would drive is done elsewhere. Turning the controller off is deferred: the enable bit stays set until the buffer-empty input reports that the internal transfer buffer has drained. At that point the running grant is dropped.

Top module: `dma_prio_arbiter`

## Requirements
- R1: The control byte reads back as {enable at bit 7, 0 at bit 6, 0 at bits 5:4, pairing code at bits 3:2, priority code at bits 1:0}. Bits 6:4 of a write are never stored, and every field is zero after reset.
- R2: With priority code 00, all four channels rotate. The next grant goes to the first requesting channel after the last one granted, in cyclic index order, and channel 0 comes first after reset.
- R3: With priority code 01, a requesting channel 0 always wins. Otherwise channels 1, 2 and 3 rotate, with channel 1 first after reset.
- R4: With priority code 10, channel 0 beats channel 1 and both beat channels 2 and 3. Channels 2 and 3 rotate, with channel 2 first after reset.
- R5: With priority code 11, the grant goes to the lowest-numbered requesting channel.
- R6: The grant is one-hot or zero. A new grant appears one clock after an idle, enabled cycle that has requests. It stays unchanged, whatever the requests do, until the cycle carrying xfer_done. It is zero on the next cycle.
- R7: While the controller is disabled, grant is zero whatever the requests.
- R8: A write with bit 7 clear while enabled and buf_empty low keeps ctrl_enabled high, keeps the current grant and issues no new grant. On the first clock edge with buf_empty high, ctrl_enabled and grant both drop to zero.
- R9: A write with bit 6 set while enabled does not reset anything. The write's other fields still land.
- R10: A write with bit 6 set while disabled clears the whole control byte and both rotation positions at that clock edge. The rest of the written byte is discarded.
- R11: dbuf_pair[0] is set when the pairing code is 01 or 11 (channels 0 and 1 paired). dbuf_pair[1] is set when it is 10 or 11 (channels 2 and 3 paired).
- R12: The rotation position moves to the granted channel only when xfer_done ends a grant to a channel of the rotating group. A grant cut off by a disable leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 4 | Per-channel transfer requests |
| xfer_done | input | 1 | One-cycle pulse closing the granted transfer |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte write data |
| buf_empty | input | 1 | High when the internal transfer buffer is empty |
| grant | output | 4 | One-hot grant, zero when idle |
| cfg_rdata | output | 8 | Control byte readback |
| ctrl_enabled | output | 1 | Controller enable status |
| dbuf_pair | output | 2 | Double-buffer pairing flags (bit 0: channels 0/1, bit 1: channels 2/3) |

## Verification
For every priority code, the arbiter starts from a fresh software reset. It is then fed all sixteen request patterns in ascending order, a burst of all-channels-requesting cycles and a scrambled tail. The ascending sweep separates the fixed part of each scheme from the rotating part. The saturated burst shows whether the rotation position really advances, and by how much. Separate sequences cut a grant off through a deferred disable, to show that the position does not advance without a done pulse, and try the reset bit in both enable states.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
    parameter int unsigned CH_N  = 4;
    localparam int unsigned CH_W  = $clog2(CH_N);
    localparam int unsigned CFG_W = 8;

    localparam int unsigned BIT_EN   = 7;
    localparam int unsigned BIT_SRST = 6;
    localparam int unsigned DBUF_LO  = 2;
    localparam int unsigned PRIO_LO  = 0;

    typedef enum logic [1:0] {
        PRIO_ROTATE_ALL = 2'b00,
        PRIO_ONE_FIXED  = 2'b01,
        PRIO_TWO_FIXED  = 2'b10,
        PRIO_ALL_FIXED  = 2'b11
    } prio_mode_e;

    // number of channels ranked strictly ahead of the rotating group
    function automatic int fixed_count(prio_mode_e mode);
        return (mode == PRIO_ALL_FIXED) ? int'(CH_N) - 1 : int'(mode);
    endfunction
endpackage

// File: rtl/dma_ctrl_reg.sv
module dma_ctrl_reg
    import dma_arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             buf_empty,
    output logic             en,
    output logic             pend,
    output logic             abort,
    output logic             soft_rst,
    output logic [1:0]       dbuf,
    output prio_mode_e       prio
);
    typedef struct packed {
        logic       en;
        logic       pend;
        logic [1:0] dbuf;
        prio_mode_e prio;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{en: 1'b0, pend: 1'b0, dbuf: 2'b00, prio: PRIO_ROTATE_ALL};

    ctrl_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        soft_rst = 1'b0;
        if (cfg_we) begin
            if (cfg_wdata[BIT_SRST] && !s_q.en) begin
                s_d      = CTRL_RST;
                soft_rst = 1'b1;
            end else begin
                s_d.dbuf = cfg_wdata[DBUF_LO +: 2];
                s_d.prio = prio_mode_e'(cfg_wdata[PRIO_LO +: 2]);
                if (cfg_wdata[BIT_EN]) begin
                    s_d.en   = 1'b1;
                    s_d.pend = 1'b0;
                end else if (s_q.en) begin
                    if (buf_empty) begin
                        s_d.en   = 1'b0;
                        s_d.pend = 1'b0;
                    end else begin
                        s_d.pend = 1'b1;
                    end
                end
            end
        end else if (s_q.pend && buf_empty) begin
            s_d.en   = 1'b0;
            s_d.pend = 1'b0;
        end
        abort = s_q.en && !s_d.en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= CTRL_RST;
        else        s_q <= s_d;
    end

    assign en   = s_q.en;
    assign pend = s_q.pend;
    assign dbuf = s_q.dbuf;
    assign prio = s_q.prio;
endmodule

// File: rtl/dma_grant_sel.sv
module dma_grant_sel
    import dma_arb_pkg::*;
(
    input  logic [CH_N-1:0] req,
    input  prio_mode_e      prio,
    input  logic [CH_W-1:0] last,
    output logic            pick_vld,
    output logic [CH_W-1:0] pick_idx
);
    int              nfix;
    logic            fix_vld, rr_vld;
    logic [CH_W-1:0] fix_idx, rr_idx, cand;

    always_comb begin
        nfix    = fixed_count(prio);
        fix_vld = 1'b0;
        fix_idx = '0;
        rr_vld  = 1'b0;
        rr_idx  = '0;
        cand    = '0;
        // fixed tier: lowest index wins, so scan downward and overwrite
        for (int i = int'(CH_N) - 1; i >= 0; i--) begin
            if (i < nfix && req[i]) begin
                fix_vld = 1'b1;
                fix_idx = CH_W'(i);
            end
        end
        // rotating tier: nearest channel after the last grant wins
        for (int s = int'(CH_N); s >= 1; s--) begin
            cand = CH_W'((int'(last) + s) % int'(CH_N));
            if (int'(cand) >= nfix && req[cand]) begin
                rr_vld = 1'b1;
                rr_idx = cand;
            end
        end
        pick_vld = fix_vld || rr_vld;
        pick_idx = fix_vld ? fix_idx : rr_idx;
    end
endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
    import dma_arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CH_N-1:0]  req,
    input  logic             xfer_done,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             buf_empty,
    output logic [CH_N-1:0]  grant,
    output logic [CFG_W-1:0] cfg_rdata,
    output logic             ctrl_enabled,
    output logic [1:0]       dbuf_pair
);
    typedef struct packed {
        logic [CH_N-1:0] grant;
        logic [CH_W-1:0] last;
    } arb_t;

    localparam arb_t ARB_RST = '{grant: '0, last: CH_W'(CH_N - 1)};

    logic            en, pend, abort, soft_rst;
    logic [1:0]      dbuf;
    prio_mode_e      prio;
    logic            pick_vld;
    logic [CH_W-1:0] pick_idx, gnt_idx;
    arb_t            s_d, s_q;

    dma_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .buf_empty (buf_empty),
        .en        (en),
        .pend      (pend),
        .abort     (abort),
        .soft_rst  (soft_rst),
        .dbuf      (dbuf),
        .prio      (prio)
    );

    dma_grant_sel u_sel (
        .req      (req),
        .prio     (prio),
        .last     (s_q.last),
        .pick_vld (pick_vld),
        .pick_idx (pick_idx)
    );

    always_comb begin
        gnt_idx = '0;
        for (int i = 0; i < int'(CH_N); i++) begin
            if (s_q.grant[i]) gnt_idx = CH_W'(i);
        end
    end

    always_comb begin
        s_d = s_q;
        if (soft_rst) begin
            s_d = ARB_RST;
        end else if (!en || abort) begin
            s_d.grant = '0;
        end else if (|s_q.grant) begin
            if (xfer_done) begin
                s_d.grant = '0;
                if (int'(gnt_idx) >= fixed_count(prio)) s_d.last = gnt_idx;
            end
        end else if (!pend && pick_vld) begin
            s_d.grant = CH_N'(1) << pick_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= ARB_RST;
        else        s_q <= s_d;
    end

    assign grant        = s_q.grant;
    assign ctrl_enabled = en;
    assign dbuf_pair    = dbuf;
    assign cfg_rdata    = {en, 1'b0, 2'b00, dbuf, prio};
endmodule

// File: rtl/dma_prio_arbiter_chk.sv
module dma_prio_arbiter_chk
    import dma_arb_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [CH_N-1:0]  req,
    input logic             xfer_done,
    input logic             cfg_we,
    input logic [CFG_W-1:0] cfg_wdata,
    input logic             buf_empty,
    input logic [CH_N-1:0]  grant,
    input logic [CFG_W-1:0] cfg_rdata,
    input logic             ctrl_enabled
);
    assert_grant_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_grant_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0 && !xfer_done) |=> (grant == $past(grant) || !ctrl_enabled));

    assert_grant_from_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0) |=> (grant == '0 || (grant & $past(req)) != '0));

    assert_no_grant_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_enabled |-> grant == '0);

    assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[6:4] == 3'b000);

    assert_deferred_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_enabled && !buf_empty) |=> ctrl_enabled);

    assert_srst_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata[7:6] == 2'b11 && ctrl_enabled) |=> ctrl_enabled);

    assert_srst_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata[6] && !ctrl_enabled) |=> cfg_rdata == '0);

    assert_ch0_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0 && req[0] && cfg_rdata[1:0] != 2'b00) |=> (grant == '0 || grant == CH_N'(1)));
endmodule

bind dma_prio_arbiter dma_prio_arbiter_chk u_chk (.*);

// File: tb/dma_prio_arbiter_bench.sv
module dma_prio_arbiter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req = '0;
    logic       xfer_done = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       buf_empty = 1'b1;
    logic [3:0] grant;
    logic [7:0] cfg_rdata;
    logic       ctrl_enabled;
    logic [1:0] dbuf_pair;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    dma_prio_arbiter u_dma_prio_arbiter (
        .clk(clk), .rst_n(rst_n), .req(req), .xfer_done(xfer_done),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .buf_empty(buf_empty),
        .grant(grant), .cfg_rdata(cfg_rdata), .ctrl_enabled(ctrl_enabled),
        .dbuf_pair(dbuf_pair)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        cfg_we = 1'b1;
        cfg_wdata = v;
        step();
        cfg_we = 1'b0;
        cfg_wdata = '0;
    endtask

    function automatic int nfix_of(input int mode);
        return (mode == 3) ? 3 : mode;
    endfunction

    // expected winner from the stated priority rules, -1 when none
    function automatic int pick(input logic [3:0] r, input int mode, input int last);
        int nf;
        nf = nfix_of(mode);
        for (int i = 0; i < nf; i++) if (r[i]) return i;
        for (int s = 1; s <= 4; s++) begin
            int c;
            c = (last + s) % 4;
            if (c >= nf && r[c]) return c;
        end
        return -1;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int last;
        string tag;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R1 reset readback", cfg_rdata, 0);
        chk("R7 reset enable", ctrl_enabled, 0);
        req = 4'hF;
        step(); step();
        chk("R7 grant while disabled", grant, 0);
        req = '0;

        for (int m = 0; m < 4; m++) begin
            case (m)
                0: tag = "R2";
                1: tag = "R3";
                2: tag = "R4";
                default: tag = "R5";
            endcase
            wr(8'h40);
            chk("R10 soft reset readback", cfg_rdata, 0);
            wr(8'h80 | 8'(m << 2) | 8'(m));
            chk("R1 readback", cfg_rdata, 'h80 | (m << 2) | m);
            chk("R11 pairing flags", dbuf_pair, m);
            last = 3;
            for (int k = 0; k < 36; k++) begin
                logic [3:0] p;
                int e;
                p = (k < 16) ? 4'(k) : (k < 22) ? 4'hF : 4'((k * 5 + 3) % 16);
                req = p;
                step();
                e = pick(p, m, last);
                if (e < 0) begin
                    chk({tag, " idle"}, grant, 0);
                end else begin
                    chk({tag, " winner"}, grant, 1 << e);
                    req = '0;
                    step();
                    chk("R6 grant held", grant, 1 << e);
                    xfer_done = 1'b1;
                    step();
                    xfer_done = 1'b0;
                    chk("R6 grant released", grant, 0);
                    if (e >= nfix_of(m)) last = e;
                end
            end
            req = '0;
            wr(8'h00);
            chk("R8 immediate off when empty", ctrl_enabled, 0);
        end

        // deferred disable and pointer hold on abort
        wr(8'h40);
        wr(8'h80);
        req = 4'hF;
        step();
        chk("R2 first after reset", grant, 1);
        buf_empty = 1'b0;
        wr(8'h00);
        chk("R8 enable held", ctrl_enabled, 1);
        chk("R8 grant held", grant, 1);
        step(); step(); step();
        chk("R8 still enabled", ctrl_enabled, 1);
        buf_empty = 1'b1;
        step();
        chk("R8 enable dropped", ctrl_enabled, 0);
        chk("R8 grant aborted", grant, 0);
        wr(8'h80);
        step();
        chk("R12 no advance on abort", grant, 1);
        xfer_done = 1'b1;
        step();
        xfer_done = 1'b0;
        step();
        chk("R12 advance on done", grant, 2);
        xfer_done = 1'b1;
        step();
        xfer_done = 1'b0;
        req = '0;
        step();

        wr(8'hC1);
        chk("R9 reset ignored readback", cfg_rdata, 'h81);
        chk("R9 still enabled", ctrl_enabled, 1);

        wr(8'h00);
        req = 4'hF;
        step(); step();
        chk("R7 no grant after disable", grant, 0);
        req = '0;

        wr(8'h0E);
        chk("R1 fields while disabled", cfg_rdata, 'h0E);
        chk("R11 both pairs", dbuf_pair, 3);
        wr(8'h40);
        chk("R10 clears fields", cfg_rdata, 0);
        wr(8'h36);
        chk("R1 reserved bits dropped", cfg_rdata, 'h06);
        chk("R11 pair 0/1 only", dbuf_pair, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule